// File: doc/BRIEF.md
# Lookup-Table Logic Cell

This block models one configurable logic cell of a programmable fabric. Two 4-input lookup tables, called F and G, each evaluate a fully programmable function of their own four inputs. A third, 3-input table, called H, combines the F result, the G result and one extra input, `h1_i`. With this arrangement the cell can deliver two unrelated 4-input functions at once. It can also deliver any single 5-input function. Two storage flops take their data from a selectable source. Each has a clock enable and an asynchronous force input. Software-visible configuration is not part of the block: the whole personality arrives on one static vector, `cfg_i`, which the surrounding fabric holds steady.

`cfg_i` is the packed structure `cell_cfg_t`. Its fields, from most to least significant, are:

| Field | Bits | Meaning |
|---|---|---|
| `f_tt` | 16 | truth table of F |
| `g_tt` | 16 | truth table of G |
| `h_tt` | 8 | truth table of H |
| `xd_src` | 2 | data source of the X flop |
| `yd_src` | 2 | data source of the Y flop |
| `x_sr_set` | 1 | force value of the X flop |
| `y_sr_set` | 1 | force value of the Y flop |
| `x_use_h` | 1 | combinational X takes H instead of F |
| `y_use_h` | 1 | combinational Y takes H instead of G |
| `x_regd` | 1 | X output shows the X flop |
| `y_regd` | 1 | Y output shows the Y flop |

Top module: `lut_cell`

## Requirements
- R1: F outputs bit `f_tt[f_i]` and G outputs bit `g_tt[g_i]`, where input bit 0 is the least significant bit of the table index.
- R2: H outputs bit `h_tt[{h1_i, G result, F result}]`, so the F result is index bit 0 and `h1_i` is index bit 2.
- R3: With `f_tt`=16'h6996 and `h_tt`=8'h5A, output X with H selected equals the XOR of all five inputs `f_i[3:0]` and `h1_i`, for all 32 patterns.
- R4: When `x_regd`=0, `x_o` is the F result if `x_use_h`=0 and the H result if `x_use_h`=1. When `y_regd`=0, `y_o` is the G result if `y_use_h`=0 and the H result if `y_use_h`=1.
- R5: When `x_regd`=1, `x_o` equals `qx_o`; when `y_regd`=1, `y_o` equals `qy_o`.
- R6: With `ce_i`=1, `sr_i`=0 and `rst`=0, each flop loads at the rising clock edge the source named by its 2-bit select: 0 = F, 1 = G, 2 = H, 3 = `din_i`.
- R7: With `ce_i`=0 and `sr_i`=0, both flops keep their values across clock edges, whatever the other inputs do.
- R8: While `sr_i`=1, each flop is forced at once, without waiting for a clock edge, to its `*_sr_set` bit (1 = set, 0 = clear). This force overrides the clock enable and the data input.
- R9: `rst` is synchronous and active high. It clears both flops to 0 at the clock edge, with priority over the clock enable.
- R10: The two combinational outputs can carry two independent 4-input functions at the same time: F on X and G on Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| cfg_i | input | 50 | static cell configuration (`cell_cfg_t`) |
| f_i | input | 4 | F table inputs, bit 0 = input 1 |
| g_i | input | 4 | G table inputs, bit 0 = input 1 |
| h1_i | input | 1 | extra H input |
| din_i | input | 1 | direct flop data input |
| ce_i | input | 1 | clock enable for both flops |
| sr_i | input | 1 | asynchronous force to configured set/clear value |
| x_o | output | 1 | X output, combinational or registered |
| y_o | output | 1 | Y output, combinational or registered |
| qx_o | output | 1 | X flop value |
| qy_o | output | 1 | Y flop value |

## Verification
The bench builds the cell at its defaults: two 4-input tables and a 3-input merging table. This makes the whole 5-input space, 32 patterns, exhaustive for the parity personality. Random truth tables and random select fields exercise every data source and every output mode against a reference model in the bench. Directed sequences show three cases: the force acting between clock edges, the force winning over an enabled clock, and reset clearing both flops when they hold 1.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    localparam int FG_K  = 4;
    localparam int FG_TT = 1 << FG_K;
    localparam int H_K   = 3;
    localparam int H_TT  = 1 << H_K;
    localparam int N_FF  = 2;

    // flop data source encoding
    typedef enum logic [1:0] {
        DS_F   = 2'd0,
        DS_G   = 2'd1,
        DS_H   = 2'd2,
        DS_DIN = 2'd3
    } dsrc_e;

    typedef struct packed {
        logic [FG_TT-1:0] f_tt;
        logic [FG_TT-1:0] g_tt;
        logic [H_TT-1:0]  h_tt;
        dsrc_e            xd_src;
        dsrc_e            yd_src;
        logic             x_sr_set;
        logic             y_sr_set;
        logic             x_use_h;
        logic             y_use_h;
        logic             x_regd;
        logic             y_regd;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    function automatic logic pick_src(dsrc_e s, logic f, logic g, logic h, logic din);
        logic r;
        case (s)
            DS_F:    r = f;
            DS_G:    r = g;
            DS_H:    r = h;
            default: r = din;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lut_fgen.sv
module lut_fgen #(
    parameter int K  = 4,
    localparam int TT = 1 << K
) (
    input  logic [TT-1:0] tt,
    input  logic [K-1:0]  sel,
    output logic          y
);
    always_comb y = tt[sel];
endmodule

// File: rtl/cell_ff.sv
module cell_ff (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic sr,
    input  logic sr_val,
    input  logic d,
    output logic q
);
    // force is asynchronous and wins over reset and enable
    always_ff @(posedge clk or posedge sr) begin
        if (sr)
            q <= sr_val;
        else if (rst)
            q <= 1'b0;
        else if (ce)
            q <= d;
    end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [FG_K-1:0]  f_i,
    input  logic [FG_K-1:0]  g_i,
    input  logic             h1_i,
    input  logic             din_i,
    input  logic             ce_i,
    input  logic             sr_i,
    output logic             x_o,
    output logic             y_o,
    output logic             qx_o,
    output logic             qy_o
);
    cell_cfg_t cfg;
    logic      f_out, g_out, h_out;

    logic [FG_TT-1:0] tt_fg  [2];
    logic [FG_K-1:0]  sel_fg [2];
    logic [1:0]       y_fg;

    always_comb begin
        cfg       = cell_cfg_t'(cfg_i);
        tt_fg[0]  = cfg.f_tt;
        tt_fg[1]  = cfg.g_tt;
        sel_fg[0] = f_i;
        sel_fg[1] = g_i;
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_fg
        lut_fgen #(.K(FG_K)) u_gen (
            .tt  (tt_fg[gi]),
            .sel (sel_fg[gi]),
            .y   (y_fg[gi])
        );
    end

    assign f_out = y_fg[0];
    assign g_out = y_fg[1];

    lut_fgen #(.K(H_K)) u_hgen (
        .tt  (cfg.h_tt),
        .sel ({h1_i, g_out, f_out}),
        .y   (h_out)
    );

    logic [N_FF-1:0] ff_d, ff_set, ff_q;

    always_comb begin
        ff_d[0]   = pick_src(cfg.xd_src, f_out, g_out, h_out, din_i);
        ff_d[1]   = pick_src(cfg.yd_src, f_out, g_out, h_out, din_i);
        ff_set[0] = cfg.x_sr_set;
        ff_set[1] = cfg.y_sr_set;
    end

    for (genvar fi = 0; fi < N_FF; fi++) begin : g_ff
        cell_ff u_ff (
            .clk    (clk),
            .rst    (rst),
            .ce     (ce_i),
            .sr     (sr_i),
            .sr_val (ff_set[fi]),
            .d      (ff_d[fi]),
            .q      (ff_q[fi])
        );
    end

    logic x_comb, y_comb;
    always_comb begin
        x_comb = cfg.x_use_h ? h_out : f_out;
        y_comb = cfg.y_use_h ? h_out : g_out;
        x_o    = cfg.x_regd ? ff_q[0] : x_comb;
        y_o    = cfg.y_regd ? ff_q[1] : y_comb;
        qx_o   = ff_q[0];
        qy_o   = ff_q[1];
    end
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk
    import lut_cell_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CFG_W-1:0] cfg_i,
    input logic             f_out,
    input logic             g_out,
    input logic             h_out,
    input logic             din_i,
    input logic             ce_i,
    input logic             sr_i,
    input logic             qx_o,
    input logic             qy_o
);
    cell_cfg_t c;
    logic      dx, dy;
    always_comb begin
        c  = cell_cfg_t'(cfg_i);
        dx = pick_src(c.xd_src, f_out, g_out, h_out, din_i);
        dy = pick_src(c.yd_src, f_out, g_out, h_out, din_i);
    end

    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        (ce_i && !sr_i) |=> (sr_i || (qx_o == $past(dx) && qy_o == $past(dy))));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!ce_i && !sr_i) |=> (sr_i || ($stable(qx_o) && $stable(qy_o))));

    assert_force_R8: assert property (@(posedge clk) disable iff (rst)
        sr_i |-> (qx_o == c.x_sr_set && qy_o == c.y_sr_set));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !sr_i && !$past(sr_i)) |-> (!qx_o && !qy_o));
endmodule

bind lut_cell lut_cell_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .cfg_i (cfg_i),
    .f_out (f_out),
    .g_out (g_out),
    .h_out (h_out),
    .din_i (din_i),
    .ce_i  (ce_i),
    .sr_i  (sr_i),
    .qx_o  (qx_o),
    .qy_o  (qy_o)
);

// File: tb/tb_lut_cell.sv
module tb_lut_cell;
    import lut_cell_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    cell_cfg_t       c;
    logic [FG_K-1:0] f_i = '0, g_i = '0;
    logic            h1_i = 1'b0, din_i = 1'b0, ce_i = 1'b0, sr_i = 1'b0;
    logic            x_o, y_o, qx_o, qy_o;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    lut_cell dut (
        .clk(clk), .rst(rst), .cfg_i(c), .f_i(f_i), .g_i(g_i), .h1_i(h1_i),
        .din_i(din_i), .ce_i(ce_i), .sr_i(sr_i),
        .x_o(x_o), .y_o(y_o), .qx_o(qx_o), .qy_o(qy_o)
    );

    function automatic logic rf(cell_cfg_t k, logic [3:0] a); return k.f_tt[a]; endfunction
    function automatic logic rg(cell_cfg_t k, logic [3:0] a); return k.g_tt[a]; endfunction
    function automatic logic rh(cell_cfg_t k, logic [3:0] a, logic [3:0] b, logic e);
        return k.h_tt[{e, rg(k, b), rf(k, a)}];
    endfunction
    function automatic logic rsrc(dsrc_e s, cell_cfg_t k, logic [3:0] a, logic [3:0] b,
                                  logic e, logic d);
        case (s)
            DS_F:    return rf(k, a);
            DS_G:    return rg(k, b);
            DS_H:    return rh(k, a, b, e);
            default: return d;
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic rand_cfg();
        c.f_tt     = 16'($urandom);
        c.g_tt     = 16'($urandom);
        c.h_tt     = 8'($urandom);
        c.xd_src   = dsrc_e'($urandom_range(0, 3));
        c.yd_src   = dsrc_e'($urandom_range(0, 3));
        c.x_sr_set = 1'($urandom);
        c.y_sr_set = 1'($urandom);
        c.x_use_h  = 1'($urandom);
        c.y_use_h  = 1'($urandom);
    endtask

    task automatic rand_in();
        f_i   = 4'($urandom);
        g_i   = 4'($urandom);
        h1_i  = 1'($urandom);
        din_i = 1'($urandom);
    endtask

    initial begin
        void'($urandom(32'd1234));
        c = '0;
        c.x_regd = 1'b1;
        c.y_regd = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset qx", qx_o, 1'b0);
        check("R9 reset qy", qy_o, 1'b0);
        check("R5 reset x_o", x_o, 1'b0);
        rst = 1'b0;

        // R3: 5-input parity, exhaustive
        c = '0;
        c.f_tt = 16'h6996;
        c.h_tt = 8'h5A;
        c.x_use_h = 1'b1;
        for (int p = 0; p < 32; p++) begin
            f_i  = p[3:0];
            h1_i = p[4];
            #2;
            check("R3 parity", x_o, ^p[4:0]);
        end

        // R1 R2 R4 R10: random tables and output selects
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rand_cfg();
            c.x_regd = 1'b0;
            c.y_regd = 1'b0;
            rand_in();
            #2;
            check(c.x_use_h ? "R2 R4 x_o from H" : "R1 R10 x_o from F", x_o,
                  c.x_use_h ? rh(c, f_i, g_i, h1_i) : rf(c, f_i));
            check(c.y_use_h ? "R2 R4 y_o from H" : "R1 R10 y_o from G", y_o,
                  c.y_use_h ? rh(c, f_i, g_i, h1_i) : rg(c, g_i));
        end

        // R6 R5: registered loads from every source
        ce_i = 1'b1;
        for (int i = 0; i < 40; i++) begin
            logic ex, ey;
            @(negedge clk);
            rand_cfg();
            c.x_regd = 1'b1;
            c.y_regd = 1'b1;
            rand_in();
            ex = rsrc(c.xd_src, c, f_i, g_i, h1_i, din_i);
            ey = rsrc(c.yd_src, c, f_i, g_i, h1_i, din_i);
            @(negedge clk);
            check("R6 qx load", qx_o, ex);
            check("R6 qy load", qy_o, ey);
            check("R5 x_o registered", x_o, ex);
            check("R5 y_o registered", y_o, ey);
        end

        // R7: enable low holds
        begin
            logic hx, hy;
            @(negedge clk);
            hx = qx_o;
            hy = qy_o;
            ce_i = 1'b0;
            c.xd_src = DS_DIN;
            c.yd_src = DS_DIN;
            din_i = ~hx;
            rand_in();
            din_i = ~hx;
            repeat (3) @(negedge clk);
            check("R7 qx held", qx_o, hx);
            check("R7 qy held", qy_o, hy);
        end

        // R8: asynchronous force, overrides enable
        @(negedge clk);
        ce_i = 1'b1;
        din_i = 1'b1;
        @(negedge clk);
        check("R6 preload qy", qy_o, 1'b1);
        c.x_sr_set = 1'b1;
        c.y_sr_set = 1'b0;
        din_i = 1'b0;
        #2;
        ce_i = 1'b0;
        sr_i = 1'b1;
        #2;
        check("R8 async set qx", qx_o, 1'b1);
        check("R8 async clear qy", qy_o, 1'b0);
        ce_i = 1'b1;
        @(negedge clk);
        check("R8 set beats enable", qx_o, 1'b1);
        check("R8 clear holds", qy_o, 1'b0);
        sr_i = 1'b0;
        @(negedge clk);
        check("R6 after force", qx_o, 1'b0);

        // R9: reset clears with enable high
        din_i = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 clear qx", qx_o, 1'b0);
        check("R9 clear qy", qy_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule